// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block is the digital control core of a smart card reader front end. It brings a card's supply, data lines, clock and reset up in a fixed order when the host pulls its active-low session command low. It takes them down in the reverse order when the command returns high, or when a fault appears during a session. All event times are counted in half units of T, where T is 64 cycles of the block clock (the internal oscillator). A half-T prescaler restarts at the beginning of each power-up and each power-down, so every event lands on an exact cycle.

The analog supply, its slope control and the card clock divider sit outside the block. The block drives their enables and a two-bit voltage code. A digital supply-settled input reports whether the card supply is at its target level. The active-low status line reports card presence to the host, and it stays low after an emergency power-down until the host withdraws the session command. With no session running, the host can put the front end into a low-power stop state by holding the command and both voltage-select lines high.

Top module: `scs_sequencer`

## Requirements
- R1: `osc_fast_o` goes high in the first cycle after the edge that samples `cmd_n_i` low (t1), and `vcc_en_o` rises 3 half-T later. `io_en_o` rises 8 half-T after t1, and activation ends 14 half-T after t1. From then on `rst_o` follows `rst_in_i` combinationally. Before the end of activation `rst_o` is 0.
- R2: `vsel_o` is loaded at t1 with 2'b01 when `sel_18_i` is high (1.8 V, which wins over `sel_5_i`), with 2'b11 when only `sel_5_i` is high (5 V), and with 2'b10 when both are low (3 V). It holds that value until power-down completes, then reads 2'b00. Select changes during a session do not affect it.
- R3: If `rst_in_i` is low at t1, `clk_en_o` rises together with `io_en_o`. If it is high, the clock stays off until the host lowers `rst_in_i` at or after data enable, and then rises one cycle later. At the end of activation the clock is on regardless.
- R4: A power-down starts at the edge that samples `cmd_n_i` high (t10), and `rst_o` is 0 from t10. `clk_en_o` drops 1 half-T after t10, `io_en_o` drops 2 half-T after t10, and `vcc_en_o` drops 6 half-T after t10. An output that was off at t10 stays off.
- R5: A power-down ends at the first edge at which at least 6 half-T have elapsed and `vcc_ok_i` is low. At that edge `osc_fast_o` drops. A new session command is not accepted before this point.
- R6: During a session, any of the following is a fault: `ovc_i`, `otemp_i` or `uv_i` high, `present_i` low, or `vcc_ok_i` low from data enable onward. A fault drives `off_n_o` low on the next edge and runs the R4 power-down. `off_n_o` stays low, and no new session starts, until `cmd_n_i` is high while the block is inactive.
- R7: When no fault is latched, `off_n_o` equals `present_i`. While the card is unpowered, `ovc_i` and `otemp_i` have no effect on `off_n_o` or on the next session.
- R8: From the inactive state, `cmd_n_i`, `sel_18_i` and `sel_5_i` all high put the block into stop (`stop_o` high) on the next edge. A power-down that is already running completes first. Stop ends on the edge after any of the three inputs goes low.
- R9: `uv_i` high or `present_i` low in the inactive state blocks activation. `osc_fast_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_n_i | input | 1 | Session command, low requests a powered card |
| rst_in_i | input | 1 | Host card-reset request, also gates the clock start |
| sel_18_i | input | 1 | 1.8 V select, has priority |
| sel_5_i | input | 1 | 5 V (high) or 3 V (low) select |
| present_i | input | 1 | Debounced card presence |
| ovc_i | input | 1 | Card supply overcurrent |
| otemp_i | input | 1 | Overtemperature |
| uv_i | input | 1 | Host supply undervoltage |
| vcc_ok_i | input | 1 | Card supply at its target level |
| osc_fast_o | output | 1 | High oscillator rate request, high through a whole sequence |
| vcc_en_o | output | 1 | Card supply generator enable |
| vsel_o | output | 2 | Voltage code: 00 off, 01 1.8 V, 10 3 V, 11 5 V |
| io_en_o | output | 1 | Data and auxiliary line enable |
| clk_en_o | output | 1 | Card clock enable |
| rst_o | output | 1 | Card reset line |
| off_n_o | output | 1 | Active-low status/interrupt to host |
| stop_o | output | 1 | Low-power stop indication |

## Verification
A wrong state or a miscounted half-T shows up as one of the five card enables switching one prescaler period (32 cycles) early or late. The bench therefore samples each edge on both sides of its expected cycle. A lost fault latch shows as `off_n_o` rising before the host withdraws the command, or as a session restarting by itself, and is visible within a cycle of the inactive state. A voltage code that is not held shows as `vsel_o` changing while the selects move during a power-down.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_STOP, ST_ACT, ST_ON, ST_DEACT} st_e;
  typedef enum logic [1:0] {VC_OFF = 2'b00, VC_1V8 = 2'b01, VC_3V0 = 2'b10, VC_5V0 = 2'b11} vcode_e;

  localparam int unsigned PH_W = 4;
  // event points in half-T units from the start of a sequence
  localparam int unsigned PH_RAMP    = 3;
  localparam int unsigned PH_IO      = 8;
  localparam int unsigned PH_END     = 14;
  localparam int unsigned PH_CLK_OFF = 1;
  localparam int unsigned PH_IO_OFF  = 2;
  localparam int unsigned PH_VCC_OFF = 6;
endpackage

// File: rtl/scs_timebase.sv
module scs_timebase import scs_pkg::*; #(
  parameter int unsigned OSC_PER_T = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  output logic            tick_o,
  output logic [PH_W-1:0] half_o
);
  localparam int unsigned HALF  = OSC_PER_T / 2;
  localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  half_q;

  assign tick_o = (div_q == DIV_W'(HALF - 1));
  assign half_o = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      half_q <= '0;
    end else if (clr_i) begin
      div_q  <= '0;
      half_q <= '0;
    end else if (tick_o) begin
      div_q <= '0;
      if (half_q != '1) half_q <= half_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/scs_vsel.sv
module scs_vsel import scs_pkg::*; (
  input  logic   sel_18_i,
  input  logic   sel_5_i,
  output vcode_e code_o
);
  always_comb begin
    if (sel_18_i)     code_o = VC_1V8;
    else if (sel_5_i) code_o = VC_5V0;
    else              code_o = VC_3V0;
  end
endmodule

// File: rtl/scs_outs.sv
module scs_outs import scs_pkg::*; (
  input  st_e             state_i,
  input  logic [PH_W-1:0] half_i,
  input  logic            clk_go_i,
  input  logic            vcc_on_i,
  input  logic            io_on_i,
  input  logic            clk_on_i,
  input  logic            rst_in_i,
  output logic            osc_fast_o,
  output logic            vcc_en_o,
  output logic            io_en_o,
  output logic            clk_en_o,
  output logic            rst_o
);
  always_comb begin
    osc_fast_o = 1'b0;
    vcc_en_o   = 1'b0;
    io_en_o    = 1'b0;
    clk_en_o   = 1'b0;
    rst_o      = 1'b0;
    unique case (state_i)
      ST_ACT: begin
        osc_fast_o = 1'b1;
        vcc_en_o   = half_i >= PH_W'(PH_RAMP);
        io_en_o    = half_i >= PH_W'(PH_IO);
        clk_en_o   = (half_i >= PH_W'(PH_IO)) && clk_go_i;
      end
      ST_ON: begin
        osc_fast_o = 1'b1;
        vcc_en_o   = 1'b1;
        io_en_o    = 1'b1;
        clk_en_o   = 1'b1;
        rst_o      = rst_in_i;
      end
      ST_DEACT: begin
        osc_fast_o = 1'b1;
        vcc_en_o   = vcc_on_i && (half_i < PH_W'(PH_VCC_OFF));
        io_en_o    = io_on_i  && (half_i < PH_W'(PH_IO_OFF));
        clk_en_o   = clk_on_i && (half_i < PH_W'(PH_CLK_OFF));
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/scs_sequencer.sv
module scs_sequencer import scs_pkg::*; #(
  parameter int unsigned OSC_PER_T = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_n_i,
  input  logic       rst_in_i,
  input  logic       sel_18_i,
  input  logic       sel_5_i,
  input  logic       present_i,
  input  logic       ovc_i,
  input  logic       otemp_i,
  input  logic       uv_i,
  input  logic       vcc_ok_i,
  output logic       osc_fast_o,
  output logic       vcc_en_o,
  output logic [1:0] vsel_o,
  output logic       io_en_o,
  output logic       clk_en_o,
  output logic       rst_o,
  output logic       off_n_o,
  output logic       stop_o
);
  st_e             state_q, state_d;
  logic [PH_W-1:0] half;
  logic            tick, tb_clr;
  logic            fault_q, clk_go_q, vcc_on_q, io_on_q, clk_on_q;
  vcode_e          vsel_q, vsel_new;
  logic            in_session, supply_need, fault_now, start_ok, stop_req;

  scs_timebase #(.OSC_PER_T(OSC_PER_T)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tb_clr),
    .tick_o (tick),
    .half_o (half)
  );

  scs_vsel u_vsel (
    .sel_18_i (sel_18_i),
    .sel_5_i  (sel_5_i),
    .code_o   (vsel_new)
  );

  scs_outs u_outs (
    .state_i    (state_q),
    .half_i     (half),
    .clk_go_i   (clk_go_q),
    .vcc_on_i   (vcc_on_q),
    .io_on_i    (io_on_q),
    .clk_on_i   (clk_on_q),
    .rst_in_i   (rst_in_i),
    .osc_fast_o (osc_fast_o),
    .vcc_en_o   (vcc_en_o),
    .io_en_o    (io_en_o),
    .clk_en_o   (clk_en_o),
    .rst_o      (rst_o)
  );

  assign in_session  = (state_q == ST_ACT) || (state_q == ST_ON);
  assign supply_need = (state_q == ST_ON) || ((state_q == ST_ACT) && (half >= PH_W'(PH_IO)));
  assign fault_now   = ovc_i || otemp_i || uv_i || !present_i || (supply_need && !vcc_ok_i);
  assign start_ok    = !cmd_n_i && !fault_q && !uv_i && present_i;
  assign stop_req    = cmd_n_i && sel_18_i && sel_5_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_ACT;
                else if (stop_req) state_d = ST_STOP;
      ST_STOP:  if (!stop_req) state_d = ST_IDLE;
      ST_ACT:   if (fault_now || cmd_n_i) state_d = ST_DEACT;
                else if (tick && half == PH_W'(PH_END - 1)) state_d = ST_ON;
      ST_ON:    if (fault_now || cmd_n_i) state_d = ST_DEACT;
      ST_DEACT: if (half >= PH_W'(PH_VCC_OFF) && !vcc_ok_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign tb_clr = (state_d != state_q) && ((state_d == ST_ACT) || (state_d == ST_DEACT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      fault_q  <= 1'b0;
      clk_go_q <= 1'b0;
      vsel_q   <= VC_OFF;
      vcc_on_q <= 1'b0;
      io_on_q  <= 1'b0;
      clk_on_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (in_session && fault_now)             fault_q <= 1'b1;
      else if (state_q == ST_IDLE && cmd_n_i)  fault_q <= 1'b0;
      if (state_q == ST_IDLE && state_d == ST_ACT) begin
        clk_go_q <= !rst_in_i;
        vsel_q   <= vsel_new;
      end else if (state_q == ST_ACT) begin
        clk_go_q <= clk_go_q || !rst_in_i;
      end
      if (state_q == ST_DEACT && state_d == ST_IDLE) vsel_q <= VC_OFF;
      // snapshot of what was on when a power-down begins
      if (state_q != ST_DEACT) begin
        vcc_on_q <= vcc_en_o;
        io_on_q  <= io_en_o;
        clk_on_q <= clk_en_o;
      end
    end
  end

  assign vsel_o  = vsel_q;
  assign off_n_o = !fault_q && present_i;
  assign stop_o  = (state_q == ST_STOP);
endmodule

// File: rtl/scs_sequencer_chk.sv
module scs_sequencer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_n_i,
  input logic       rst_in_i,
  input logic       sel_18_i,
  input logic       sel_5_i,
  input logic       present_i,
  input logic       ovc_i,
  input logic       otemp_i,
  input logic       uv_i,
  input logic       vcc_ok_i,
  input logic       osc_fast_o,
  input logic       vcc_en_o,
  input logic [1:0] vsel_o,
  input logic       io_en_o,
  input logic       clk_en_o,
  input logic       rst_o,
  input logic       off_n_o,
  input logic       stop_o
);
  assert_rst_needs_all_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> (osc_fast_o && vcc_en_o && io_en_o && clk_en_o));

  assert_vsel_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_fast_o && $past(osc_fast_o)) |-> (vsel_o == $past(vsel_o)));

  assert_io_under_vcc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> vcc_en_o);

  assert_clk_before_io_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(io_en_o) |-> !clk_en_o);

  assert_io_before_vcc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vcc_en_o) |-> !io_en_o);

  assert_fault_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovc_i && rst_o) |=> !off_n_o);

  assert_quiet_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_fast_o |-> !(vcc_en_o || io_en_o || clk_en_o || rst_o));

  assert_stop_unpowered_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> (!osc_fast_o && !vcc_en_o && vsel_o == 2'b00));
endmodule

bind scs_sequencer scs_sequencer_chk u_chk (.*);

// File: tb/test_scs_sequencer.sv
module test_scs_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_n = 1'b1, rst_in = 1'b0, sel_18 = 1'b0, sel_5 = 1'b1, present = 1'b1;
  logic ovc = 1'b0, otemp = 1'b0, uv = 1'b0, vcc_ok = 1'b0;
  logic osc_fast, vcc_en, io_en, clk_en, rst_c, off_n, stop;
  logic [1:0] vsel;
  int cyc = 0, checks = 0, errors = 0;
  bit finished = 1'b0;

  typedef struct {int at; logic [8:0] v; string tag;} item_t;
  item_t sbq[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scs_sequencer i_scs_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_n_i(cmd_n), .rst_in_i(rst_in),
    .sel_18_i(sel_18), .sel_5_i(sel_5), .present_i(present), .ovc_i(ovc),
    .otemp_i(otemp), .uv_i(uv), .vcc_ok_i(vcc_ok), .osc_fast_o(osc_fast),
    .vcc_en_o(vcc_en), .vsel_o(vsel), .io_en_o(io_en), .clk_en_o(clk_en),
    .rst_o(rst_c), .off_n_o(off_n), .stop_o(stop)
  );

  function automatic logic [8:0] pk(bit o, bit v, bit i, bit c, bit r, bit f, bit s, logic [1:0] vs);
    return {o, v, i, c, r, f, s, vs};
  endfunction

  task automatic ex(int at, logic [8:0] v, string tag);
    item_t it;
    it.at = at; it.v = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic go(int n);
    while (cyc < n) begin @(posedge clk); #1; end
  endtask

  // monitor: {osc,vcc,io,clk,rst,off_n,stop,vsel}
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      item_t it;
      logic [8:0] act;
      it  = sbq.pop_front();
      act = {osc_fast, vcc_en, io_en, clk_en, rst_c, off_n, stop, vsel};
      checks++;
      if (it.at != cyc || act !== it.v) begin
        errors++;
        $display("FAIL %s at cycle %0d: actual %b expected %b", it.tag, cyc, act, it.v);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    ex(cyc + 2, pk(0,0,0,0,0,1,0,2'b00), "R7 reset state");
    go(cyc + 4);

    // R1 R3: activation at 5 V, host reset low
    c = cyc;
    cmd_n = 1'b0;
    ex(c+1,   pk(1,0,0,0,0,1,0,2'b11), "R1 R2 start 5V");
    ex(c+96,  pk(1,0,0,0,0,1,0,2'b11), "R1 supply not yet");
    ex(c+97,  pk(1,1,0,0,0,1,0,2'b11), "R1 supply at 1.5T");
    ex(c+256, pk(1,1,0,0,0,1,0,2'b11), "R1 data not yet");
    ex(c+257, pk(1,1,1,1,0,1,0,2'b11), "R1 R3 data and clock at 4T");
    ex(c+448, pk(1,1,1,1,0,1,0,2'b11), "R1 reset held");
    ex(c+450, pk(1,1,1,1,1,1,0,2'b11), "R1 reset follows host");
    go(c+100); vcc_ok = 1'b1;
    go(c+450); rst_in = 1'b1;
    go(c+452);

    // R4 R5 R8: power-down, stop requested midway, code held
    c = cyc;
    cmd_n = 1'b1;
    ex(c+1,   pk(1,1,1,1,0,1,0,2'b11), "R4 reset low at t10");
    ex(c+32,  pk(1,1,1,1,0,1,0,2'b11), "R4 clock still on");
    ex(c+33,  pk(1,1,1,0,0,1,0,2'b11), "R4 clock off at 0.5T");
    ex(c+64,  pk(1,1,1,0,0,1,0,2'b11), "R4 data still on");
    ex(c+65,  pk(1,1,0,0,0,1,0,2'b11), "R4 data off at T");
    ex(c+100, pk(1,1,0,0,0,1,0,2'b11), "R2 code held despite select change");
    ex(c+192, pk(1,1,0,0,0,1,0,2'b11), "R4 supply still on");
    ex(c+193, pk(1,0,0,0,0,1,0,2'b11), "R4 supply off at 3T");
    ex(c+200, pk(1,0,0,0,0,1,0,2'b11), "R5 waits for supply low");
    ex(c+201, pk(0,0,0,0,0,1,0,2'b00), "R5 R8 inactive before stop");
    ex(c+202, pk(0,0,0,0,0,1,1,2'b00), "R8 stop entered");
    ex(c+210, pk(0,0,0,0,0,0,1,2'b00), "R8 status tracks absence");
    ex(c+215, pk(0,0,0,0,0,1,1,2'b00), "R8 status tracks presence");
    ex(c+220, pk(0,0,0,0,0,1,1,2'b00), "R8 stop until edge");
    ex(c+221, pk(0,0,0,0,0,1,0,2'b00), "R8 stop left");
    go(c+2);   sel_18 = 1'b1; rst_in = 1'b0;
    go(c+200); vcc_ok = 1'b0;
    go(c+210); present = 1'b0;
    go(c+215); present = 1'b1;
    go(c+220); sel_5 = 1'b0;
    go(c+224);

    // R3 R2: gated clock start at 1.8 V
    c = cyc;
    rst_in = 1'b1; cmd_n = 1'b0;
    ex(c+1,   pk(1,0,0,0,0,1,0,2'b01), "R2 1.8V code");
    ex(c+257, pk(1,1,1,0,0,1,0,2'b01), "R3 clock held by host reset");
    ex(c+300, pk(1,1,1,0,0,1,0,2'b01), "R3 clock held until edge");
    ex(c+301, pk(1,1,1,1,0,1,0,2'b01), "R3 clock after host reset low");
    ex(c+449, pk(1,1,1,1,0,1,0,2'b01), "R1 active, reset follows low");
    go(c+100); vcc_ok = 1'b1;
    go(c+300); rst_in = 1'b0;
    go(c+460);

    // R6: overcurrent during a session
    c = cyc;
    ovc = 1'b1;
    ex(c,     pk(1,1,1,1,0,1,0,2'b01), "R6 before edge");
    ex(c+1,   pk(1,1,1,1,0,0,0,2'b01), "R6 fault status and reset low");
    ex(c+33,  pk(1,1,1,0,0,0,0,2'b01), "R6 R4 emergency clock off");
    ex(c+201, pk(0,0,0,0,0,0,0,2'b00), "R6 inactive, status low");
    ex(c+210, pk(0,0,0,0,0,0,0,2'b00), "R6 no restart while command low");
    ex(c+220, pk(0,0,0,0,0,0,0,2'b00), "R6 status low until edge");
    ex(c+221, pk(0,0,0,0,0,1,0,2'b00), "R6 status released");
    go(c+5);   ovc = 1'b0;
    go(c+200); vcc_ok = 1'b0;
    go(c+220); cmd_n = 1'b1;
    go(c+224);

    // R9 R5: undervoltage blocks, then an aborted activation at 3 V
    c = cyc;
    uv = 1'b1; sel_18 = 1'b0; sel_5 = 1'b0; cmd_n = 1'b0;
    ex(c+1,   pk(0,0,0,0,0,1,0,2'b00), "R9 undervoltage blocks");
    ex(c+50,  pk(0,0,0,0,0,1,0,2'b00), "R9 still blocked");
    ex(c+61,  pk(1,0,0,0,0,1,0,2'b10), "R9 R2 start at 3V after release");
    ex(c+71,  pk(1,0,0,0,0,1,0,2'b10), "R4 abort keeps off outputs off");
    ex(c+263, pk(1,0,0,0,0,1,0,2'b10), "R5 not before 3T");
    ex(c+264, pk(0,0,0,0,0,1,0,2'b00), "R5 ends at 3T");
    go(c+60); uv = 1'b0;
    go(c+70); cmd_n = 1'b1;
    go(c+266);

    // R7 R6 R9: faults ignored when unpowered, removal in session, absent blocks
    c = cyc;
    ovc = 1'b1; otemp = 1'b1;
    ex(c+1,   pk(0,0,0,0,0,1,0,2'b00), "R7 faults ignored unpowered");
    ex(c+5,   pk(1,0,0,0,0,1,0,2'b10), "R7 session starts after ignored fault");
    ex(c+104, pk(1,1,0,0,0,0,0,2'b10), "R6 removal drops status");
    ex(c+105, pk(1,1,0,0,0,0,0,2'b10), "R6 removal power-down");
    ex(c+297, pk(1,0,0,0,0,0,0,2'b10), "R6 supply off");
    ex(c+298, pk(0,0,0,0,0,0,0,2'b00), "R6 inactive");
    ex(c+300, pk(0,0,0,0,0,0,0,2'b00), "R6 latched despite presence");
    ex(c+311, pk(0,0,0,0,0,1,0,2'b00), "R6 released by command high");
    ex(c+330, pk(0,0,0,0,0,0,0,2'b00), "R9 absent card blocks");
    go(c+2);   ovc = 1'b0; otemp = 1'b0;
    go(c+4);   cmd_n = 1'b0;
    go(c+104); present = 1'b0;
    go(c+300); present = 1'b1;
    go(c+310); cmd_n = 1'b1;
    go(c+320); present = 1'b0; cmd_n = 1'b0;
    go(c+340);

    finished = 1'b1;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule